// File: doc/BRIEF.md
# Character I/O Register Block

This block sits between a 16-bit processor's load/store bus and two simple character devices: a keyboard source and a display sink. It decodes four word addresses into a keyboard status register, a keyboard data register, a display status register and a display data register. Software polls the most significant bit of a status register, which it can test as the sign of the loaded word, and then moves one character through the matching data register.

The ready flags follow a handshake that the bus accesses themselves drive. A keyboard strobe loads a code and raises keyboard ready. The first read of keyboard data lowers that flag. A write to display data hands the character to the display and lowers display ready. The flag rises again when the display reports that the character is on the screen. Software never writes a status register to clear a flag.

Top module: `char_io_regs`

## Requirements
- R1: After reset, keyboard ready is 0, display ready is 1, both data registers read zero and `disp_start` is low.
- R2: Addresses are decoded as follows: keyboard status 0xFE00, keyboard data 0xFE02, display status 0xFE04, display data 0xFE06. Reads are combinational while `bus_rd` is high. A status read returns the ready flag in bit 15 and zeros in bits 14:0. A data read returns the 8-bit code zero-extended to 16 bits. Any other address reads zero.
- R3: A cycle with `kbd_strobe` high stores `kbd_code` in keyboard data and sets keyboard ready to 1 at that clock edge.
- R4: A read of keyboard data returns the stored code and clears keyboard ready at the same edge. Further reads return the same code and leave the flag at 0. Reading either status register changes nothing.
- R5: When a keyboard strobe and a keyboard data read fall in the same cycle, the read returns the previous code, the new code is stored, and keyboard ready ends at 1.
- R6: A write to display data while display ready is 1 captures `bus_wdata[7:0]` on `disp_char` and clears display ready. It also raises `disp_start` for exactly one cycle, starting after that edge.
- R7: A `disp_done` pulse while display ready is 0 sets it to 1. A `disp_done` pulse while display ready is already 1 has no effect, including when it falls in the same cycle as an accepted display write.
- R8: A write to display data while display ready is 0 is dropped: no start pulse, and the stored character is kept. Writes to either status register, to keyboard data or to an unmapped address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Processor word address |
| bus_rd | input | 1 | Read access this cycle |
| bus_wr | input | 1 | Write access this cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational, zero when not reading) |
| kbd_strobe | input | 1 | New keyboard code present |
| kbd_code | input | 8 | ASCII code from the keyboard |
| disp_char | output | 8 | Character handed to the display |
| disp_start | output | 1 | One-cycle pulse: new character to draw |
| disp_done | input | 1 | Display finished drawing the pending character |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a keyboard arrival and a keyboard data read. The bench raises the strobe in the same cycle that it issues the read. It expects the old code on the bus, then a set flag and the new code on later reads. The second pair is a display completion and a display data write. The bench applies this pair once while the display is busy, where the write must be dropped and the flag restored, and once while the display is idle, where the completion must be ignored and the write accepted.

// File: rtl/char_io_regs.sv
module char_io_regs #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8,
  parameter logic [ADDR_W-1:0] KBD_STAT_ADDR = 16'hFE00,
  parameter logic [ADDR_W-1:0] KBD_DATA_ADDR = 16'hFE02,
  parameter logic [ADDR_W-1:0] DSP_STAT_ADDR = 16'hFE04,
  parameter logic [ADDR_W-1:0] DSP_DATA_ADDR = 16'hFE06
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kbd_strobe,
  input  logic [CHAR_W-1:0] kbd_code,
  output logic [CHAR_W-1:0] disp_char,
  output logic              disp_start,
  input  logic              disp_done
);

  logic              kbd_rdy, dsp_rdy;
  logic [CHAR_W-1:0] kbd_data, dsp_data;

  wire sel_ks = (bus_addr == KBD_STAT_ADDR);
  wire sel_kd = (bus_addr == KBD_DATA_ADDR);
  wire sel_ds = (bus_addr == DSP_STAT_ADDR);
  wire sel_dd = (bus_addr == DSP_DATA_ADDR);

  wire kbd_take = bus_rd && sel_kd;
  wire dsp_take = bus_wr && sel_dd && dsp_rdy;

  // keyboard side: arrival wins over the read-side clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kbd_rdy  <= 1'b0;
      kbd_data <= '0;
    end else if (kbd_strobe) begin
      kbd_rdy  <= 1'b1;
      kbd_data <= kbd_code;
    end else if (kbd_take) begin
      kbd_rdy  <= 1'b0;
    end
  end

  // display side
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dsp_rdy    <= 1'b1;
      dsp_data   <= '0;
      disp_start <= 1'b0;
    end else begin
      disp_start <= dsp_take;
      if (dsp_take) begin
        dsp_rdy  <= 1'b0;
        dsp_data <= bus_wdata[CHAR_W-1:0];
      end else if (disp_done) begin
        dsp_rdy  <= 1'b1;
      end
    end
  end

  assign disp_char = dsp_data;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (sel_ks)      bus_rdata[DATA_W-1]   = kbd_rdy;
      else if (sel_kd) bus_rdata[CHAR_W-1:0] = kbd_data;
      else if (sel_ds) bus_rdata[DATA_W-1]   = dsp_rdy;
      else if (sel_dd) bus_rdata[CHAR_W-1:0] = dsp_data;
    end
  end

  assert_kbd_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_strobe |=> (kbd_rdy && kbd_data == $past(kbd_code)));

  assert_kbd_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel_kd && !kbd_strobe) |=> !kbd_rdy);

  assert_kbd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!kbd_strobe && !(bus_rd && sel_kd)) |=> ($stable(kbd_rdy) && $stable(kbd_data)));

  assert_dsp_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_dd && dsp_rdy) |=>
      (!dsp_rdy && disp_start && disp_char == $past(bus_wdata[CHAR_W-1:0])));

  assert_dsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    disp_start |=> !disp_start);

  assert_dsp_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dsp_rdy) |-> $past(disp_done));

  assert_busy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_dd && !dsp_rdy) |=> (!disp_start && $stable(disp_char)));

endmodule

// File: tb/char_io_regs_test.sv
module char_io_regs_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] bus_addr = 0;
  logic        bus_rd = 0, bus_wr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic        kbd_strobe = 0;
  logic [7:0]  kbd_code = 0;
  logic [7:0]  disp_char;
  logic        disp_start;
  logic        disp_done = 0;

  int errors = 0, checks = 0;
  bit finished = 0;

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  char_io_regs uut (.*);

  task automatic cyc(); @(posedge clk); #2; endtask

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: push expected read data, monitor compares at negedge
  task automatic rd(input logic [15:0] a, input logic [15:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    q.push_back(it);
    bus_addr = a; bus_rd = 1;
    cyc();
    bus_rd = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    cyc();
    bus_wr = 0;
  endtask

  task automatic key(input logic [7:0] c);
    kbd_code = c; kbd_strobe = 1;
    cyc();
    kbd_strobe = 0;
  endtask

  task automatic done_pulse();
    disp_done = 1;
    cyc();
    disp_done = 0;
  endtask

  always @(negedge clk) begin
    if (bus_rd) begin
      if (q.size() == 0) begin
        errors++; checks++;
        $display("FAIL monitor: read with empty queue, actual %h expected none", bus_rdata);
      end else begin
        item_t it;
        it = q.pop_front();
        chk(bus_rdata, it.exp, it.tag);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    // R1 reset state
    chk({15'd0, disp_start}, 16'h0, "R1 start low");
    rd(16'hFE00, 16'h0000, "R1 kbd status");
    rd(16'hFE04, 16'h8000, "R1 dsp status");
    rd(16'hFE02, 16'h0000, "R1 kbd data");
    rd(16'hFE06, 16'h0000, "R1 dsp data");

    // R3 / R4 keyboard path
    key(8'h41);
    rd(16'hFE00, 16'h8000, "R3 kbd ready set");
    rd(16'hFE00, 16'h8000, "R4 status read no effect");
    rd(16'hFE02, 16'h0041, "R4 first data read");
    rd(16'hFE00, 16'h0000, "R4 ready cleared");
    rd(16'hFE02, 16'h0041, "R4 second read same code");
    rd(16'hFE00, 16'h0000, "R4 flag stays 0");

    // R2 decode
    rd(16'h1234, 16'h0000, "R2 unmapped read");
    rd(16'hFE01, 16'h0000, "R2 odd address read");

    // R5 arrival and data read in same cycle
    kbd_code = 8'h5A; kbd_strobe = 1;
    rd(16'hFE02, 16'h0041, "R5 read returns old code");
    kbd_strobe = 0;
    rd(16'hFE00, 16'h8000, "R5 ready ends set");
    rd(16'hFE02, 16'h005A, "R5 new code stored");
    key(8'hC3);
    rd(16'hFE02, 16'h00C3, "R2 zero extension");

    // R6 display write
    wr(16'hFE06, 16'hAB61);
    chk({15'd0, disp_start}, 16'h1, "R6 start pulse");
    chk({8'd0, disp_char}, 16'h0061, "R6 char captured");
    cyc();
    chk({15'd0, disp_start}, 16'h0, "R6 pulse one cycle");
    rd(16'hFE04, 16'h0000, "R6 dsp ready cleared");
    rd(16'hFE06, 16'h0061, "R2 dsp data read");

    // R8 write while busy dropped
    wr(16'hFE06, 16'h0062);
    chk({15'd0, disp_start}, 16'h0, "R8 no start when busy");
    rd(16'hFE06, 16'h0061, "R8 char kept");

    // R7 completion
    done_pulse();
    rd(16'hFE04, 16'h8000, "R7 ready restored");
    done_pulse();
    rd(16'hFE04, 16'h8000, "R7 done while ready ignored");
    chk({15'd0, disp_start}, 16'h0, "R7 no start from done");

    // R8 writes elsewhere
    wr(16'hFE00, 16'h8000);
    rd(16'hFE00, 16'h0000, "R8 kbd status write ignored");
    wr(16'hFE02, 16'h0077);
    rd(16'hFE02, 16'h00C3, "R8 kbd data write ignored");
    wr(16'hFE04, 16'h0000);
    rd(16'hFE04, 16'h8000, "R8 dsp status write ignored");
    wr(16'h3000, 16'h0055);
    chk({15'd0, disp_start}, 16'h0, "R8 unmapped write no start");
    rd(16'hFE06, 16'h0061, "R8 unmapped write no change");

    // busy: write plus done in same cycle
    wr(16'hFE06, 16'h0070);
    cyc();
    bus_addr = 16'hFE06; bus_wdata = 16'h0071; bus_wr = 1; disp_done = 1;
    cyc();
    bus_wr = 0; disp_done = 0;
    chk({15'd0, disp_start}, 16'h0, "R8 busy write with done dropped");
    rd(16'hFE06, 16'h0070, "R8 char kept with done");
    rd(16'hFE04, 16'h8000, "R7 done restores during write");

    // idle: write plus done in same cycle
    bus_addr = 16'hFE06; bus_wdata = 16'h0072; bus_wr = 1; disp_done = 1;
    cyc();
    bus_wr = 0; disp_done = 0;
    chk({15'd0, disp_start}, 16'h1, "R7 write accepted with done");
    rd(16'hFE04, 16'h0000, "R7 done ignored while ready");
    rd(16'hFE06, 16'h0072, "R6 new char");

    cyc();
    chk(16'(q.size()), 16'h0, "scoreboard drained");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule